// File: doc/BRIEF.md
# Posted Write Combining Buffer

This block sits between a local source of single-word posted writes and an initiator that issues burst writes on a parallel bus. Each incoming write carries a word address, a 32-bit data word and four active-high byte enables. The buffer gathers writes into one pending burst and hands that burst to the bus side as a start address followed by a run of data phases. Every phase has its own byte enables, and the final phase is flagged.

Writes are joined only when the bus would see the same effect as issuing them one by one, in arrival order. A write may join the pending burst in three ways. It may fill other bytes of the most recent word. It may continue at the next word. It may skip a short gap, which is padded with phases that enable no bytes. A write that would reorder words, overwrite bytes already held, jump too far or run past the buffer capacity closes the burst. That write waits and then starts the next burst. A burst is also released when the buffer fills, when the flush input is raised, or after a stretch of idle cycles.

Top module: `posted_write_combiner`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1 with the buffer empty.
- R2: Writes to ascending consecutive word addresses form one burst. out_addr is the word address of the first write, phases come out in arrival order, and out_last is 1 only on the final phase. After the final phase is taken, out_valid drops on the next cycle.
- R3: A write to the same word as the most recent phase, with no byte enable in common with it, is merged into that phase. The merged enables are the OR of both writes. Enable bit i selects data bits [8i+7:8i], and those bytes take the newer data.
- R4: A write whose enables share any byte with the most recent phase of the same word is never merged. The pending burst is emitted first, and the new write then starts a burst of its own, so both values reach the output in order.
- R5: A write to a word below the most recent phase of the burst ends the burst, and that write starts a new one.
- R6: A write 2 or 3 words past the most recent phase (a gap of 1 or GAP_MAX=2 words) extends the burst. Each skipped word becomes a phase with data 0 and enables 4'b0000.
- R7: A write more than GAP_MAX+1 words past the most recent phase ends the burst and starts a new one.
- R8: When a burst reaches DEPTH=8 phases it is emitted without a flush. A write whose position (including its padding) would lie beyond phase DEPTH-1 ends the burst instead of joining it.
- R9: A flush pulse releases a non-empty burst. A flush with an empty buffer produces no output. A write is not accepted in a cycle with flush high.
- R10: With no write accepted, a non-empty burst stays held through 15 idle cycles and is released (out_valid 1) after the 16th idle clock edge.
- R11: While out_valid is 1 and out_ready is 0, the address, data, enables and last flag hold steady. in_ready stays 0 whenever out_valid is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Request to release the pending burst |
| in_valid | input | 1 | Write request present |
| in_ready | output | 1 | Write accepted this cycle when in_valid is also 1 |
| in_addr | input | 30 | Word address of the write |
| in_data | input | 32 | Write data |
| in_be | input | 4 | Byte enables, bit i for data bits [8i+7:8i] |
| out_valid | output | 1 | Burst phase available |
| out_ready | input | 1 | Bus side takes the phase |
| out_addr | output | 30 | Word address of the first phase of the burst |
| out_data | output | 32 | Phase data |
| out_be | output | 4 | Phase byte enables |
| out_last | output | 1 | Final phase of the burst |

## Verification
The assertions assume that the write source holds a request steady until it is accepted. They also assume the address arithmetic of a burst never crosses the top of the word address space, since offsets are computed modulo the address width. The directed stimulus keeps in_valid and its fields fixed from assertion until in_ready is seen, and it uses addresses far from either end of the space. Back-pressure is applied only by holding out_ready low over whole cycles, which lets the steady-output property be exercised without breaking those assumptions.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
    localparam int WCB_AW  = 30;
    localparam int WCB_DW  = 32;
    localparam int WCB_BEW = WCB_DW / 8;

    typedef logic [WCB_AW-1:0]  waddr_t;
    typedef logic [WCB_DW-1:0]  word_t;
    typedef logic [WCB_BEW-1:0] be_t;

    typedef struct packed {
        word_t data;
        be_t   be;
    } phase_t;

    typedef struct packed {
        waddr_t addr;
        word_t  data;
        be_t    be;
    } wreq_t;

    typedef enum logic [1:0] {
        JOIN_NEW    = 2'd0,
        JOIN_SAME   = 2'd1,
        JOIN_APPEND = 2'd2,
        JOIN_BREAK  = 2'd3
    } join_e;

    typedef enum logic {
        ST_GATHER = 1'b0,
        ST_EMIT   = 1'b1
    } state_e;

    function automatic phase_t merge_bytes(phase_t old, wreq_t w);
        phase_t r;
        r = old;
        for (int b = 0; b < WCB_BEW; b++) begin
            if (w.be[b]) r.data[8*b +: 8] = w.data[8*b +: 8];
        end
        r.be = old.be | w.be;
        return r;
    endfunction
endpackage

// File: rtl/wcb_join_ctl.sv
module wcb_join_ctl
    import wcb_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int GAP_MAX = 2,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  waddr_t        base,
    input  be_t           last_be,
    input  wreq_t         req,
    output join_e         kind,
    output logic [CW-1:0] idx,
    output logic [CW-1:0] fill_lo
);
    waddr_t off;
    waddr_t cnt_w;
    waddr_t last_w;

    always_comb begin
        off     = req.addr - base;
        cnt_w   = waddr_t'(count);
        last_w  = cnt_w - waddr_t'(1);
        kind    = JOIN_BREAK;
        idx     = count;
        fill_lo = count;
        if (count == '0) begin
            kind    = JOIN_NEW;
            idx     = '0;
            fill_lo = '0;
        end else if (off == last_w) begin
            if ((req.be & last_be) == '0) begin
                kind = JOIN_SAME;
                idx  = count - CW'(1);
            end
        end else if (off >= cnt_w && off <= cnt_w + waddr_t'(GAP_MAX)
                     && off < waddr_t'(DEPTH)) begin
            kind = JOIN_APPEND;
            idx  = off[CW-1:0];
        end
    end
endmodule

// File: rtl/wcb_phase_store.sv
module wcb_phase_store
    import wcb_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int GAP_MAX = 2,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int IW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  join_e         kind,
    input  logic [CW-1:0] idx,
    input  logic [CW-1:0] fill_lo,
    input  wreq_t         req,
    input  logic          clear,
    input  logic [CW-1:0] rd_idx,
    output phase_t        rd_phase,
    output logic [CW-1:0] count,
    output be_t           last_be
);
    phase_t        ph [DEPTH];
    logic [CW-1:0] last_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ph[g] <= '0;
            end else if (wr_en) begin
                if (CW'(g) == idx) begin
                    if (kind == JOIN_SAME) ph[g] <= merge_bytes(ph[g], req);
                    else                   ph[g] <= phase_t'{data: req.data, be: req.be};
                end else if (CW'(g) >= fill_lo && CW'(g) < idx) begin
                    ph[g] <= '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (wr_en) begin
            if (kind == JOIN_NEW)         count <= CW'(1);
            else if (kind == JOIN_APPEND) count <= idx + CW'(1);
        end
    end

    assign last_idx = count - CW'(1);
    assign last_be  = ph[last_idx[IW-1:0]].be;
    assign rd_phase = ph[rd_idx[IW-1:0]];

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R3
    same_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && kind == JOIN_SAME |-> (req.be & last_be) == '0);

    // R7
    gap_limit_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && kind == JOIN_APPEND |-> (idx - fill_lo) <= CW'(GAP_MAX));
endmodule

// File: rtl/wcb_idle_timer.sv
module wcb_idle_timer #(
    parameter int IDLE_CYCLES = 16,
    localparam int TW         = $clog2(IDLE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic kick,
    output logic expire
);
    logic [TW-1:0] cnt;

    assign expire = arm && !kick && cnt == TW'(IDLE_CYCLES - 1);

    always_ff @(posedge clk) begin
        if (rst || !arm || kick) cnt <= '0;
        else if (!expire)        cnt <= cnt + TW'(1);
    end

    // R10
    expire_armed_chk: assert property (@(posedge clk) disable iff (rst)
        expire |-> arm && $past(arm));
endmodule

// File: rtl/posted_write_combiner.sv
module posted_write_combiner
    import wcb_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int GAP_MAX     = 2,
    parameter int IDLE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WCB_AW-1:0] in_addr,
    input  logic [WCB_DW-1:0] in_data,
    input  logic [WCB_BEW-1:0] in_be,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WCB_AW-1:0] out_addr,
    output logic [WCB_DW-1:0] out_data,
    output logic [WCB_BEW-1:0] out_be,
    output logic              out_last
);
    localparam int CW = $clog2(DEPTH + 1);

    state_e        state;
    waddr_t        base;
    wreq_t         req;
    join_e         kind;
    logic [CW-1:0] idx, fill_lo, count, rd_idx, new_count;
    be_t           last_be;
    phase_t        rd_phase;
    logic          accept, nonempty, expire, clear, beat, go_emit;

    assign req       = wreq_t'{addr: in_addr, data: in_data, be: in_be};
    assign nonempty  = count != '0;
    assign in_ready  = state == ST_GATHER && !flush && kind != JOIN_BREAK;
    assign accept    = in_valid && in_ready;
    assign new_count = (kind == JOIN_SAME) ? count : idx + CW'(1);
    assign beat      = out_valid && out_ready;
    assign clear     = beat && out_last;

    wcb_join_ctl #(.DEPTH(DEPTH), .GAP_MAX(GAP_MAX)) i_join (
        .count(count), .base(base), .last_be(last_be), .req(req),
        .kind(kind), .idx(idx), .fill_lo(fill_lo)
    );

    wcb_phase_store #(.DEPTH(DEPTH), .GAP_MAX(GAP_MAX)) i_store (
        .clk(clk), .rst(rst), .wr_en(accept), .kind(kind), .idx(idx),
        .fill_lo(fill_lo), .req(req), .clear(clear), .rd_idx(rd_idx),
        .rd_phase(rd_phase), .count(count), .last_be(last_be)
    );

    wcb_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) i_timer (
        .clk(clk), .rst(rst), .arm(state == ST_GATHER && nonempty),
        .kick(accept), .expire(expire)
    );

    always_comb begin
        go_emit = 1'b0;
        if (state == ST_GATHER) begin
            if (flush && nonempty)                        go_emit = 1'b1;
            else if (in_valid && kind == JOIN_BREAK)      go_emit = 1'b1;
            else if (accept && new_count == CW'(DEPTH))   go_emit = 1'b1;
            else if (expire)                              go_emit = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_GATHER;
            rd_idx <= '0;
            base   <= '0;
        end else begin
            if (accept && kind == JOIN_NEW) base <= in_addr;
            case (state)
                ST_GATHER: if (go_emit) state <= ST_EMIT;
                ST_EMIT: if (beat) begin
                    if (out_last) begin
                        state  <= ST_GATHER;
                        rd_idx <= '0;
                    end else begin
                        rd_idx <= rd_idx + CW'(1);
                    end
                end
                default: state <= ST_GATHER;
            endcase
        end
    end

    assign out_valid = state == ST_EMIT;
    assign out_addr  = base;
    assign out_data  = rd_phase.data;
    assign out_be    = rd_phase.be;
    assign out_last  = rd_idx == count - CW'(1);

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_addr)
            && $stable(out_data) && $stable(out_be) && $stable(out_last));

    // R11
    no_accept_emit_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R2
    last_closes_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last |=> !out_valid);

    // R9
    flush_block_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> !accept);
endmodule

// File: tb/test_posted_write_combiner.sv
`timescale 1ns/1ps
module test_posted_write_combiner;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [29:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_be = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [29:0] out_addr;
    logic [31:0] out_data;
    logic [3:0]  out_be;
    logic        out_last;

    int checks = 0;
    int fails  = 0;

    logic [29:0] cap_addr [$];
    logic [31:0] cap_data [$];
    logic [3:0]  cap_be   [$];
    logic        cap_last [$];

    always #2 clk = ~clk;

    posted_write_combiner i_posted_write_combiner (
        .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
        .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
        .in_be(in_be), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_data(out_data), .out_be(out_be),
        .out_last(out_last)
    );

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            cap_addr.push_back(out_addr);
            cap_data.push_back(out_data);
            cap_be.push_back(out_be);
            cap_last.push_back(out_last);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_cap();
        cap_addr.delete(); cap_data.delete(); cap_be.delete(); cap_last.delete();
    endtask

    task automatic expect_n(input int n, input string req);
        check(cap_data.size() == n, req, "beat count", 64'(cap_data.size()), 64'(n));
    endtask

    task automatic expect_beat(input int k, input logic [29:0] a, input logic [31:0] d,
                               input logic [3:0] b, input logic l, input string req);
        if (k >= cap_data.size()) begin
            check(1'b0, req, $sformatf("beat %0d missing", k), 64'(cap_data.size()), 64'(k + 1));
        end else begin
            check(cap_addr[k] == a && cap_data[k] == d && cap_be[k] == b && cap_last[k] == l,
                  req, $sformatf("beat %0d addr/data/be/last", k),
                  {cap_addr[k], cap_data[k][27:0], cap_be[k], 1'b0, cap_last[k]},
                  {a, d[27:0], b, 1'b0, l});
        end
    endtask

    // called just after a rising edge; returns just after the accepting edge
    task automatic wr(input logic [29:0] a, input logic [31:0] d, input logic [3:0] b);
        in_valid = 1'b1; in_addr = a; in_data = d; in_be = b;
        forever begin
            @(negedge clk);
            if (in_ready) begin
                @(posedge clk); #1;
                in_valid = 1'b0;
                break;
            end
        end
    endtask

    task automatic pulse_flush_and_wait();
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
        repeat (12) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
        @(posedge clk); #1;
    endtask

    task automatic t_sequential();
        clear_cap();
        wr(30'h10, 32'h1111_0000, 4'hF);
        wr(30'h11, 32'h2222_0001, 4'hF);
        wr(30'h12, 32'h3333_0002, 4'h7);
        pulse_flush_and_wait();
        expect_n(3, "R2");
        expect_beat(0, 30'h10, 32'h1111_0000, 4'hF, 1'b0, "R2");
        expect_beat(1, 30'h10, 32'h2222_0001, 4'hF, 1'b0, "R2");
        expect_beat(2, 30'h10, 32'h3333_0002, 4'h7, 1'b1, "R2");
    endtask

    task automatic t_merge_same();
        clear_cap();
        wr(30'h20, 32'h0000_1234, 4'b0011);
        wr(30'h20, 32'h5678_FFFF, 4'b1100);
        pulse_flush_and_wait();
        expect_n(1, "R3");
        expect_beat(0, 30'h20, 32'h5678_1234, 4'hF, 1'b1, "R3");
    endtask

    task automatic t_overlap();
        clear_cap();
        wr(30'h30, 32'hAAAA_AAAA, 4'hF);
        wr(30'h30, 32'h0000_00BB, 4'b0001);
        pulse_flush_and_wait();
        expect_n(2, "R4");
        expect_beat(0, 30'h30, 32'hAAAA_AAAA, 4'hF, 1'b1, "R4");
        expect_beat(1, 30'h30, 32'h0000_00BB, 4'b0001, 1'b1, "R4");
    endtask

    task automatic t_backward();
        clear_cap();
        wr(30'h41, 32'h0000_0041, 4'hF);
        wr(30'h40, 32'h0000_0040, 4'hF);
        pulse_flush_and_wait();
        expect_n(2, "R5");
        expect_beat(0, 30'h41, 32'h0000_0041, 4'hF, 1'b1, "R5");
        expect_beat(1, 30'h40, 32'h0000_0040, 4'hF, 1'b1, "R5");
    endtask

    task automatic t_gap();
        clear_cap();
        wr(30'h50, 32'hC0C0_0050, 4'hF);
        wr(30'h53, 32'hC0C0_0053, 4'hF);
        wr(30'h55, 32'hC0C0_0055, 4'h3);
        pulse_flush_and_wait();
        expect_n(6, "R6");
        expect_beat(0, 30'h50, 32'hC0C0_0050, 4'hF, 1'b0, "R6");
        expect_beat(1, 30'h50, 32'h0, 4'h0, 1'b0, "R6");
        expect_beat(2, 30'h50, 32'h0, 4'h0, 1'b0, "R6");
        expect_beat(3, 30'h50, 32'hC0C0_0053, 4'hF, 1'b0, "R6");
        expect_beat(4, 30'h50, 32'h0, 4'h0, 1'b0, "R6");
        expect_beat(5, 30'h50, 32'hC0C0_0055, 4'h3, 1'b1, "R6");
    endtask

    task automatic t_big_gap();
        clear_cap();
        wr(30'h60, 32'h0000_0060, 4'hF);
        wr(30'h64, 32'h0000_0064, 4'hF);
        pulse_flush_and_wait();
        expect_n(2, "R7");
        expect_beat(0, 30'h60, 32'h0000_0060, 4'hF, 1'b1, "R7");
        expect_beat(1, 30'h64, 32'h0000_0064, 4'hF, 1'b1, "R7");
    endtask

    task automatic t_full();
        clear_cap();
        for (int i = 0; i < 8; i++) wr(30'h70 + 30'(i), 32'hF000_0000 + 32'(i), 4'hF);
        repeat (12) @(posedge clk);
        #1;
        expect_n(8, "R8");
        expect_beat(0, 30'h70, 32'hF000_0000, 4'hF, 1'b0, "R8");
        expect_beat(6, 30'h70, 32'hF000_0006, 4'hF, 1'b0, "R8");
        expect_beat(7, 30'h70, 32'hF000_0007, 4'hF, 1'b1, "R8");
    endtask

    task automatic t_capacity_gap();
        clear_cap();
        for (int i = 0; i < 6; i++) wr(30'hB0 + 30'(i), 32'hB000_0000 + 32'(i), 4'hF);
        wr(30'hB8, 32'hB000_0008, 4'hF);
        pulse_flush_and_wait();
        expect_n(7, "R8");
        expect_beat(5, 30'hB0, 32'hB000_0005, 4'hF, 1'b1, "R8");
        expect_beat(6, 30'hB8, 32'hB000_0008, 4'hF, 1'b1, "R8");
    endtask

    task automatic t_flush_empty();
        clear_cap();
        pulse_flush_and_wait();
        expect_n(0, "R9");
        @(negedge clk);
        check(in_ready == 1'b1, "R9", "in_ready idle", 64'(in_ready), 64'd1);
        // write held while flush is high
        flush = 1'b1; in_valid = 1'b1; in_addr = 30'hC0; in_be = 4'hF;
        #0.1;
        check(in_ready == 1'b0, "R9", "in_ready with flush", 64'(in_ready), 64'd0);
        @(posedge clk); #1;
        flush = 1'b0; in_valid = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        expect_n(0, "R9");
    endtask

    task automatic t_idle();
        clear_cap();
        wr(30'h80, 32'h0000_0080, 4'hF);
        repeat (15) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R10", "out_valid after 15 idle", 64'(out_valid), 64'd0);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b1, "R10", "out_valid after 16 idle", 64'(out_valid), 64'd1);
        repeat (4) @(posedge clk);
        #1;
        expect_n(1, "R10");
        expect_beat(0, 30'h80, 32'h0000_0080, 4'hF, 1'b1, "R10");
    endtask

    task automatic t_backpressure();
        clear_cap();
        out_ready = 1'b0;
        wr(30'h90, 32'h9090_0000, 4'hF);
        wr(30'h91, 32'h9090_0001, 4'hF);
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b1, "R11", "out_valid held", 64'(out_valid), 64'd1);
        check(out_data == 32'h9090_0000, "R11", "first data", 64'(out_data), 64'h9090_0000);
        in_valid = 1'b1; in_addr = 30'h92; in_data = 32'h9090_0002; in_be = 4'hF;
        #0.1;
        check(in_ready == 1'b0, "R11", "in_ready while emitting", 64'(in_ready), 64'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_data == 32'h9090_0000 && out_be == 4'hF && out_last == 1'b0,
              "R11", "stable under stall", 64'(out_data), 64'h9090_0000);
        in_valid = 1'b0;
        @(posedge clk); #1;
        out_ready = 1'b1;
        repeat (6) @(posedge clk);
        #1;
        expect_n(2, "R11");
        expect_beat(0, 30'h90, 32'h9090_0000, 4'hF, 1'b0, "R11");
        expect_beat(1, 30'h90, 32'h9090_0001, 4'hF, 1'b1, "R11");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_sequential();
        t_merge_same();
        t_overlap();
        t_backward();
        t_gap();
        t_big_gap();
        t_full();
        t_capacity_gap();
        t_flush_empty();
        t_idle();
        t_backpressure();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule